// File: doc/BRIEF.md
# Streaming Feature-Map Zero Padder

This block sits in a streaming dataflow pipeline and grows a square image by a border of zero-valued pixels. The image arrives with channels innermost: rows, then columns, then channel folds, each fold being one bus word that carries SIMD channel elements of ELEM_W bits. A pixel therefore occupies NUM_CH/SIMD consecutive beats. On the output side the block produces a square of side IMG_DIM+PAD. At every border position it emits whole groups of all-zero beats, and at interior positions it forwards input words unchanged.

Row, column and fold counters advance only on accepted output beats, so backpressure freezes the position. Input words are taken only at interior positions, and only in a cycle where the output side accepts the word being forwarded. With padding style 2 an odd total padding puts the extra row and column at the bottom and the right. The block runs NUM_IMG images back to back and then goes quiet until the next reset. Both sides use a valid/ready handshake, and the path from input to output is combinational, with no storage.

Top module: `zpad_stream`

## Requirements
- R1: After a clock edge with rst_n low, out_valid and in_ready are both low.
- R2: The interior output beats, in order, are exactly the input words in arrival order. All NUM_IMG·IMG_DIM²·NUM_CH/SIMD input words are consumed.
- R3: Each image produces (IMG_DIM+PAD)²·NUM_CH/SIMD output beats. Every beat at a border pixel position is all zero, and the fold counter returns to 0 after fold NUM_CH/SIMD-1.
- R4: With PAD_STYLE 2, the top rows and left columns get floor(PAD/2) padding and the bottom and right sides get the rest. For PAD=3 this means 1 leading and 2 trailing. The first interior beat has output index floor(PAD/2)·(ODIM+1)·FOLD, and the last interior beat of an image is followed by ceil(PAD/2)·(ODIM+1)·FOLD border beats.
- R5: An input word is accepted (in_valid and in_ready high) only in a cycle where out_valid and out_ready are both high.
- R6: When no output beat is accepted, the row, column and fold position is unchanged in the next cycle.
- R7: At an interior position with in_valid low, out_valid is low. No zero is inserted in place of missing data.
- R8: Once NUM_IMG images are complete, out_valid and in_ready stay low and further input is ignored.
- R9: The data buses are ELEM_W·SIMD bits wide. The behaviour above holds for SIMD of 1 and of 2 with NUM_CH=4, that is for 4 and for 2 beats per pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word available |
| in_ready | output | 1 | Input word taken this cycle |
| in_data | input | ELEM_W*SIMD | Input word, SIMD channel elements |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | ELEM_W*SIMD | Output word, forwarded or zero |

## Verification
Random image data with every lane forced non-zero is streamed through the block under four ready/valid duty patterns. The patterns are free flow, downstream stalls only, upstream gaps only, and both together. Each output beat is compared with a padded reference array. The stall patterns separate counters that wrongly advance under backpressure from correct ones, and the gap patterns catch zero insertion in place of late data. Two instances with 2 beats and 4 beats per pixel expose errors in fold counting. Index checks on the first and last interior beat pin down which side receives the odd padding row and column.

// File: rtl/zpad_pkg.sv
package zpad_pkg;

  // counter width able to hold values 0..n
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

  // side length after padding
  function automatic int out_dim(input int idim, input int pad);
    return idim + pad;
  endfunction

  // beats per pixel
  function automatic int fold_count(input int ch, input int simd);
    return ch / simd;
  endfunction

  // leading (top/left) padding; style 2 gives the odd extra to the trailing side
  function automatic int lead_pad(input int pad, input int style);
    return (style == 2) ? (pad / 2) : ((pad + 1) / 2);
  endfunction

  // position lies inside the copied image window along one axis
  function automatic logic in_window(input int pos, input int lead, input int idim);
    return (pos >= lead) && (pos < lead + idim);
  endfunction

endpackage

// File: rtl/zpad_pos_cnt.sv
module zpad_pos_cnt #(
  parameter int ODIM = 7,
  parameter int FOLD = 2,
  parameter int NIMG = 2,
  parameter int CW   = 3,
  parameter int FW   = 2,
  parameter int IW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] row,
  output logic [CW-1:0] col,
  output logic [FW-1:0] fold,
  output logic          done
);
  localparam logic [CW-1:0] POS_MAX  = CW'(ODIM - 1);
  localparam logic [FW-1:0] FOLD_MAX = FW'(FOLD - 1);
  localparam logic [IW-1:0] IMG_MAX  = IW'(NIMG - 1);

  logic [IW-1:0] img;
  logic fold_wrap, col_wrap, row_wrap;

  assign fold_wrap = (fold == FOLD_MAX);
  assign col_wrap  = fold_wrap && (col == POS_MAX);
  assign row_wrap  = col_wrap && (row == POS_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row  <= '0;
      col  <= '0;
      fold <= '0;
      img  <= '0;
      done <= 1'b0;
    end else if (step) begin
      fold <= fold_wrap ? '0 : fold + 1'b1;
      if (fold_wrap) col <= (col == POS_MAX) ? '0 : col + 1'b1;
      if (col_wrap)  row <= (row == POS_MAX) ? '0 : row + 1'b1;
      if (row_wrap) begin
        if (img == IMG_MAX) done <= 1'b1;
        else                img  <= img + 1'b1;
      end
    end
  end
endmodule

// File: rtl/zpad_window.sv
module zpad_window #(
  parameter int CW   = 3,
  parameter int IDIM = 4,
  parameter int LEAD = 1
) (
  input  logic [CW-1:0] row,
  input  logic [CW-1:0] col,
  output logic          interior
);
  import zpad_pkg::*;

  logic [CW-1:0] pos [2];
  logic [1:0]    hit;

  assign pos[0] = row;
  assign pos[1] = col;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    assign hit[a] = in_window(int'(pos[a]), LEAD, IDIM);
  end

  assign interior = &hit;
endmodule

// File: rtl/zpad_stream.sv
module zpad_stream #(
  parameter int ELEM_W    = 8,
  parameter int SIMD      = 2,
  parameter int NUM_CH    = 4,
  parameter int IMG_DIM   = 4,
  parameter int PAD       = 3,
  parameter int PAD_STYLE = 2,
  parameter int NUM_IMG   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [ELEM_W*SIMD-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [ELEM_W*SIMD-1:0] out_data
);
  import zpad_pkg::*;

  localparam int DW   = ELEM_W * SIMD;
  localparam int ODIM = out_dim(IMG_DIM, PAD);
  localparam int FOLD = fold_count(NUM_CH, SIMD);
  localparam int LEAD = lead_pad(PAD, PAD_STYLE);
  localparam int CW   = cnt_w(ODIM);
  localparam int FW   = cnt_w(FOLD);
  localparam int IW   = cnt_w(NUM_IMG);

  // named internal events, observed by the bound checker
  logic          live_q;
  logic          active;
  logic          interior;
  logic          beat_fire;
  logic          done;
  logic [CW-1:0] row;
  logic [CW-1:0] col;
  logic [FW-1:0] fold;

  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  zpad_pos_cnt #(
    .ODIM(ODIM), .FOLD(FOLD), .NIMG(NUM_IMG), .CW(CW), .FW(FW), .IW(IW)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .step(beat_fire),
    .row(row), .col(col), .fold(fold), .done(done)
  );

  zpad_window #(.CW(CW), .IDIM(IMG_DIM), .LEAD(LEAD)) u_win (
    .row(row), .col(col), .interior(interior)
  );

  assign active    = live_q && !done;
  assign out_valid = active && (interior ? in_valid : 1'b1);
  assign in_ready  = active && interior && out_ready;
  assign out_data  = interior ? in_data : {DW{1'b0}};
  assign beat_fire = out_valid && out_ready;
endmodule

// File: rtl/zpad_stream_chk.sv
module zpad_stream_chk #(
  parameter int DW   = 16,
  parameter int CW   = 3,
  parameter int FW   = 2,
  parameter int FOLD = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          interior,
  input logic          beat_fire,
  input logic          done,
  input logic [CW-1:0] row,
  input logic [CW-1:0] col,
  input logic [FW-1:0] fold
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!out_valid && !in_ready)); // R1
  AST_BORDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !interior) |-> (out_data == '0)); // R3
  AST_FOLD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && fold == FW'(FOLD - 1)) |=> (fold == '0)); // R3
  AST_TAKE_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (out_valid && out_ready)); // R5
  AST_HOLD_POS: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_fire |=> ($stable(row) && $stable(col) && $stable(fold))); // R6
  AST_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (interior && !in_valid) |-> !out_valid); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !in_ready)); // R8
endmodule

bind zpad_stream zpad_stream_chk #(
  .DW(DW), .CW(CW), .FW(FW), .FOLD(FOLD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .interior(interior), .beat_fire(beat_fire), .done(done),
  .row(row), .col(col), .fold(fold)
);

// File: tb/tb_zpad_core.sv
module tb_zpad_core #(
  parameter int SIMD = 2
) (
  input  logic clk,
  output logic fin,
  output int   n_cmp,
  output int   n_bad
);
  localparam int ELEM_W  = 8;
  localparam int NUM_CH  = 4;
  localparam int IDIM    = 4;
  localparam int PAD     = 3;
  localparam int NIMG    = 2;
  localparam int DW      = ELEM_W * SIMD;
  localparam int FOLD    = NUM_CH / SIMD;
  localparam int ODIM    = IDIM + PAD;
  localparam int TOPL    = PAD / 2;
  localparam int BOTR    = PAD - TOPL;
  localparam int PER_IMG = ODIM * ODIM * FOLD;
  localparam int TOTAL   = NIMG * PER_IMG;
  localparam int NIN     = NIMG * IDIM * IDIM * FOLD;

  // stimulus table: [15:8] out_ready mask, [7:0] in_valid mask, bit = cycle mod 8
  localparam logic [15:0] STIM [4] = '{16'hFFFF, 16'hA5FF, 16'hFF6D, 16'h935A};

  logic rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [DW-1:0] in_data, out_data;
  logic [DW-1:0] din [NIN];

  zpad_stream #(
    .ELEM_W(ELEM_W), .SIMD(SIMD), .NUM_CH(NUM_CH), .IMG_DIM(IDIM),
    .PAD(PAD), .PAD_STYLE(2), .NUM_IMG(NIMG)
  ) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (SIMD=%0d) actual=%0h expected=%0h", req, SIMD, act, exp);
    end
  endtask

  // reference position of output beat k: inside the copied window, and source index
  function automatic bit ref_inside(input int k, output int src);
    int img, r, c, f;
    img = k / PER_IMG;
    r   = (k % PER_IMG) / (ODIM * FOLD);
    c   = (k % (ODIM * FOLD)) / FOLD;
    f   = k % FOLD;
    src = ((img * IDIM + r - TOPL) * IDIM + (c - TOPL)) * FOLD + f;
    return (r >= TOPL) && (r < TOPL + IDIM) && (c >= TOPL) && (c < TOPL + IDIM);
  endfunction

  initial begin
    logic [31:0] lcg;
    fin = 1'b0; rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    lcg = 32'h1234_0000 + SIMD;
    for (int e = 0; e < 4; e++) begin
      int out_k, in_k, first_int, last_int, cyc, src;
      bit ins;
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_data = '0;
      repeat (2) @(negedge clk);
      chk(!out_valid && !in_ready, "R1 reset quiet", {out_valid, in_ready}, 0);
      for (int i = 0; i < NIN; i++) begin
        lcg = lcg * 32'd1103515245 + 32'd12345;
        din[i] = DW'(lcg >> 8);
        for (int l = 0; l < SIMD; l++) din[i][l*ELEM_W] = 1'b1;
      end
      rst_n = 1'b1;
      out_k = 0; in_k = 0; first_int = -1; last_int = -1; cyc = 0;
      while (out_k < TOTAL && cyc < 6000) begin
        @(negedge clk);
        out_ready = STIM[e][8 + (cyc % 8)];
        in_valid  = STIM[e][cyc % 8] && (in_k < NIN);
        in_data   = (in_k < NIN) ? din[in_k] : '0;
        #1;
        ins = ref_inside(out_k, src);
        if (ins && !in_valid)
          chk(!out_valid, "R7 no fill on missing input", out_valid, 0);
        chk(!(in_ready && !out_ready), "R5 input only with output", in_ready, 0);
        if (out_valid && out_ready) begin
          if (ins) begin
            chk(out_data == din[src], "R2 interior word", out_data, din[src]);
            if (first_int < 0) first_int = out_k;
            last_int = out_k;
          end else begin
            chk(out_data == '0, "R3 border zero", out_data, 0);
          end
          out_k++;
        end
        if (in_valid && in_ready) in_k++;
        cyc++;
      end
      chk(out_k == TOTAL, "R3 beat count", out_k, TOTAL);
      chk(in_k == NIN, "R2 all input consumed", in_k, NIN);
      chk(first_int == TOPL * (ODIM + 1) * FOLD, "R4 leading split",
          first_int, TOPL * (ODIM + 1) * FOLD);
      chk(TOTAL - 1 - last_int == BOTR * (ODIM + 1) * FOLD, "R4 trailing split",
          TOTAL - 1 - last_int, BOTR * (ODIM + 1) * FOLD);
      // R8: after the last image, input offered is ignored
      in_valid = 1'b1; out_ready = 1'b1; in_data = '1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); #1;
        chk(!out_valid && !in_ready, "R8 quiet after last image",
            {out_valid, in_ready}, 0);
      end
    end
    fin = 1'b1;
  end
endmodule

// File: tb/tb_zpad_stream.sv
module tb_zpad_stream;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic fin2, fin1;
  int cmp2, bad2, cmp1, bad1;

  // R9: two bus widths, 2 and 4 beats per pixel
  tb_zpad_core #(.SIMD(2)) u_simd2 (.clk(clk), .fin(fin2), .n_cmp(cmp2), .n_bad(bad2));
  tb_zpad_core #(.SIMD(1)) u_simd1 (.clk(clk), .fin(fin1), .n_cmp(cmp1), .n_bad(bad1));

  initial begin
    int wd, total_bad;
    wd = 0;
    while ((fin2 !== 1'b1 || fin1 !== 1'b1) && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    total_bad = bad2 + bad1;
    if (wd >= 100000) begin
      total_bad++;
      $display("FAIL watchdog: run did not complete, actual=%0d expected<100000", wd);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             cmp2 + cmp1 + ((wd >= 100000) ? 1 : 0), total_bad);
    $finish;
  end
endmodule